// File: doc/BRIEF.md
# Multi-mode serial clock generator

This block produces the transmit and receive bit-timing pulses for one serial channel. The pulses are enables in the system clock domain. A base clock is taken from the system clock, either at the full rate or at half rate. A prescaler then offers that base rate and two slower taps: the base rate divided by 8 and by 32. A two-bit source field picks one of these taps. The selected tap drives an 8-bit reloading divider that divides by n+1.

The divider output then goes through a post-divider that depends on the mode:

- **UART mode:** the output is divided by 16, and the transmit and receive enables fire together.
- **Clock-synchronous mode with the internal clock:** the output toggles a serial clock level, which is driven out on the clock pin. A receive enable fires on each rising edge of that clock and a transmit enable on each falling edge.
- **Clock-synchronous mode with the external clock:** the clock pin is an input. It is synchronized with two flops, and its edges produce the enables in place of the internal divider.

A polarity bit inverts the pin clock in both directions.

Top module: `serclk_gen`

## Requirements
- R1: While `rst` is high, `tx_tick` and `rx_tick` are 0 and `sclk_out` equals `clk_inv`.
- R2: `base_full`=1 makes the base clock one tick per system cycle. `base_full`=0 makes it one tick every 2 cycles.
- R3: The `src_sel` field chooses the divider input: 2'b00 the base tick, 2'b01 the base tick divided by 8, 2'b10 the base tick divided by 32, and 2'b11 behaves as 2'b00.
- R4: The divider emits one output per `div_n`+1 selected-tap ticks.
- R5: A new `div_n` is only taken when the divider counter reloads, so the interval already running keeps the old length.
- R6: With `sync_mode`=0, `tx_tick` and `rx_tick` pulse in the same cycle, once per 16 divider outputs.
- R7: With `sync_mode`=1 and `ext_clk_sel`=0, the internal serial clock toggles at each divider output. `rx_tick` fires on its rising edge and `tx_tick` on its falling edge, and `sclk_oe`=1.
- R8: With `sync_mode`=1 and `ext_clk_sel`=1, `sclk_oe`=0 and the internal divider has no effect on the ticks. A rising pin edge (with `clk_inv`=0) gives an `rx_tick` 2 cycles after the first sampling edge, and a falling pin edge gives a `tx_tick` after the same delay.
- R9: `clk_inv`=1 inverts the clock in both directions: `sclk_out` is the internal level inverted, and a rising pin edge is treated as a falling clock edge.
- R10: `tx_tick` and `rx_tick` never stay high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_full | input | 1 | 1: base clock is the system clock; 0: the system clock halved |
| src_sel | input | 2 | Prescaler tap select (00 /1, 01 /8, 10 /32, 11 /1) |
| div_n | input | 8 | Divider reload value n (divides by n+1) |
| sync_mode | input | 1 | 0: UART mode; 1: clock-synchronous mode |
| ext_clk_sel | input | 1 | 1: external pin clock in synchronous mode |
| clk_inv | input | 1 | Invert the pin clock polarity |
| sclk_in | input | 1 | Clock pin input level |
| sclk_out | output | 1 | Clock pin output level |
| sclk_oe | output | 1 | Clock pin output enable |
| tx_tick | output | 1 | Transmit bit enable pulse |
| rx_tick | output | 1 | Receive bit enable pulse |

## Verification
The tick outputs are combinational from registered counters, so each tick is visible in the same cycle that the counters reach their terminal values. The bench therefore checks them through the spacing between pulses, sampled at falling clock edges. Periods and half periods are compared against b·m·(n+1)·16 in UART mode and b·m·(n+1) per half period in synchronous mode.

An external pin edge gives its tick at the second falling-edge sample after the pin changes, because of the two synchronizer stages. A divider reload value changed in mid-interval shows up one interval later, and the checks sample exactly at those points.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
    localparam int DIV_W   = 8;
    localparam int PRE_W   = 5;   // prescaler counter covers /32
    localparam int POST_W  = 4;   // UART post-divide by 16

    typedef enum logic [1:0] {
        SRC_BASE  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV32 = 2'b10,
        SRC_RSVD  = 2'b11
    } src_e;

    typedef struct packed {
        logic base;
        logic div8;
        logic div32;
    } taps_t;

    function automatic logic pick_tap(input taps_t t, input src_e s);
        case (s)
            SRC_DIV8:  pick_tap = t.div8;
            SRC_DIV32: pick_tap = t.div32;
            default:   pick_tap = t.base;   // 00 and reserved 11
        endcase
    endfunction
endpackage

// File: rtl/serclk_prescale.sv
module serclk_prescale
    import serclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  base_full,
    output taps_t taps
);
    logic             half_ph;
    logic [PRE_W-1:0] pre_cnt;
    logic             base_tick;

    assign base_tick = !rst && (base_full || half_ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_ph <= 1'b0;
            pre_cnt <= '0;
        end else begin
            half_ph <= ~half_ph;
            if (base_tick) pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign taps.base  = base_tick;
    assign taps.div8  = base_tick && (pre_cnt[2:0] == 3'd7);
    assign taps.div32 = base_tick && (&pre_cnt);

    // R3: every /32 tap coincides with a /8 tap
    p_div32_on_div8_r3: assert property (@(posedge clk) disable iff (rst)
        taps.div32 |-> taps.div8);
endmodule

// File: rtl/serclk_brg.sv
module serclk_brg
    import serclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tap_tick,
    input  logic [DIV_W-1:0] div_n,
    output logic             brg_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] n_cur;

    assign brg_tick = tap_tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            n_cur <= '0;
        end else if (tap_tick) begin
            if (cnt == '0) begin
                cnt   <= div_n;   // new value taken only at reload
                n_cur <= div_n;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R5: the running count never exceeds the value loaded at the last reload
    p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= n_cur);
    // R4: a reload copies the programmed value into the counter
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        brg_tick |=> cnt == $past(div_n));
endmodule

// File: rtl/serclk_post.sv
module serclk_post
    import serclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic brg_tick,
    input  logic sync_mode,
    input  logic ext_clk_sel,
    input  logic clk_inv,
    input  logic sclk_in,
    output logic sclk_out,
    output logic sclk_oe,
    output logic tx_tick,
    output logic rx_tick
);
    logic [POST_W-1:0] u_cnt;
    logic              uart_tick;
    logic              clk_lvl;
    logic [2:0]        pin_sync;
    logic              pin_now, pin_prev;
    logic              ext_rise, ext_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            u_cnt    <= '0;
            clk_lvl  <= 1'b0;
            pin_sync <= '0;
        end else begin
            pin_sync <= {pin_sync[1:0], sclk_in};
            if (brg_tick) begin
                u_cnt   <= u_cnt + 1'b1;
                clk_lvl <= ~clk_lvl;
            end
        end
    end

    assign uart_tick = brg_tick && (&u_cnt);
    assign pin_now   = pin_sync[1] ^ clk_inv;
    assign pin_prev  = pin_sync[2] ^ clk_inv;
    assign ext_rise  = pin_now && !pin_prev;
    assign ext_fall  = !pin_now && pin_prev;

    always_comb begin
        if (!sync_mode) begin
            tx_tick = uart_tick;
            rx_tick = uart_tick;
        end else if (ext_clk_sel) begin
            tx_tick = ext_fall;
            rx_tick = ext_rise;
        end else begin
            tx_tick = brg_tick && clk_lvl;
            rx_tick = brg_tick && !clk_lvl;
        end
    end

    assign sclk_out = clk_lvl ^ clk_inv;
    assign sclk_oe  = sync_mode && !ext_clk_sel;

    // R6: a UART tick closes a 16-output group
    p_uart_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (uart_tick && !sync_mode) |=> u_cnt == '0);
    // R7: in synchronous mode receive and transmit edges never coincide
    p_sync_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        sync_mode |-> !(tx_tick && rx_tick));
    // R7: the internal clock level only moves on a divider output
    p_lvl_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !brg_tick |=> $stable(clk_lvl));
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
    import serclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             base_full,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] div_n,
    input  logic             sync_mode,
    input  logic             ext_clk_sel,
    input  logic             clk_inv,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             tx_tick,
    output logic             rx_tick
);
    taps_t taps;
    logic  tap_tick;
    logic  brg_tick;

    serclk_prescale u_pre (
        .clk(clk), .rst(rst), .base_full(base_full), .taps(taps)
    );

    assign tap_tick = pick_tap(taps, src_e'(src_sel));

    serclk_brg u_brg (
        .clk(clk), .rst(rst), .tap_tick(tap_tick),
        .div_n(div_n), .brg_tick(brg_tick)
    );

    serclk_post u_post (
        .clk(clk), .rst(rst), .brg_tick(brg_tick), .sync_mode(sync_mode),
        .ext_clk_sel(ext_clk_sel), .clk_inv(clk_inv), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    // R10: transmit enable is a single-cycle pulse
    p_tx_single_r10: assert property (@(posedge clk) disable iff (rst)
        tx_tick |=> !tx_tick);
    // R10: receive enable is a single-cycle pulse
    p_rx_single_r10: assert property (@(posedge clk) disable iff (rst)
        rx_tick |=> !rx_tick);
endmodule

// File: tb/tb_serclk_gen.sv
module tb_serclk_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_full = 1'b1;
    logic [1:0] src_sel = 2'b00;
    logic [7:0] div_n = 8'd0;
    logic       sync_mode = 1'b0;
    logic       ext_clk_sel = 1'b0;
    logic       clk_inv = 1'b0;
    logic       sclk_in = 1'b0;
    logic       sclk_out, sclk_oe, tx_tick, rx_tick;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    serclk_gen dut (
        .clk(clk), .rst(rst), .base_full(base_full), .src_sel(src_sel),
        .div_n(div_n), .sync_mode(sync_mode), .ext_clk_sel(ext_clk_sel),
        .clk_inv(clk_inv), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act cycles=%0d exp < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run = n_run + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // count negedge samples until the chosen tick is seen (want_rx selects rx)
    task automatic count_to(input bit want_rx, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!(want_rx ? rx_tick : tx_tick) && n < 20000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // fields: full[27] src[26:25] n[24:17] sync[16] expected tx period[15:0]
    localparam logic [27:0] VEC [8] = '{
        {1'b1, 2'b00, 8'd0, 1'b0, 16'd16},    // R2 R4 R6 full rate
        {1'b0, 2'b00, 8'd0, 1'b0, 16'd32},    // R2 halved
        {1'b1, 2'b01, 8'd2, 1'b0, 16'd384},   // R3 /8 tap
        {1'b0, 2'b10, 8'd1, 1'b0, 16'd2048},  // R3 /32 tap
        {1'b1, 2'b11, 8'd3, 1'b0, 16'd64},    // R3 reserved acts as /1
        {1'b1, 2'b00, 8'd4, 1'b1, 16'd10},    // R7 sync internal
        {1'b0, 2'b01, 8'd0, 1'b1, 16'd32},    // R7 halved /8
        {1'b1, 2'b10, 8'd0, 1'b1, 16'd64}     // R7 /32
    };

    initial begin
        int a, b;

        // R1: reset state
        clk_inv = 1'b1;
        sync_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 tx_tick in reset", int'(tx_tick), 0);
        check("R1 rx_tick in reset", int'(rx_tick), 0);
        check("R1 sclk_out idle", int'(sclk_out), 1);
        clk_inv = 1'b0;

        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rst = 1'b1;
            base_full = VEC[i][27];
            src_sel   = VEC[i][26:25];
            div_n     = VEC[i][24:17];
            sync_mode = VEC[i][16];
            ext_clk_sel = 1'b0;
            do_reset();
            count_to(1'b0, a);
            if (!VEC[i][16]) begin
                count_to(1'b0, a);
                check($sformatf("R2 R3 R4 R6 vec%0d period", i), a, int'(VEC[i][15:0]));
                check("R6 rx with tx", int'(rx_tick), 1);
            end else begin
                count_to(1'b1, a);
                count_to(1'b0, b);
                check($sformatf("R7 vec%0d tx->rx", i), a, int'(VEC[i][15:0]) / 2);
                check($sformatf("R7 vec%0d rx->tx", i), b, int'(VEC[i][15:0]) / 2);
                check("R7 sclk_oe", int'(sclk_oe), 1);
            end
        end

        // R9: inverted pin output in sync internal mode
        @(negedge clk);
        rst = 1'b1;
        base_full = 1'b1; src_sel = 2'b00; div_n = 8'd2;
        sync_mode = 1'b1; clk_inv = 1'b1;
        do_reset();
        count_to(1'b1, a);
        check("R9 sclk_out at rx edge (inv)", int'(sclk_out), 1);
        @(negedge clk);
        check("R7 R9 sclk_out after rise (inv)", int'(sclk_out), 0);
        count_to(1'b0, a);
        check("R9 sclk_out at tx edge (inv)", int'(sclk_out), 0);

        // R5: divider change mid-interval
        @(negedge clk);
        rst = 1'b1;
        clk_inv = 1'b0; div_n = 8'd9;
        do_reset();
        count_to(1'b0, a);
        repeat (2) @(negedge clk);
        div_n = 8'd1;
        count_to(1'b1, a);
        check("R5 old n kept in running interval", a + 2, 10);
        count_to(1'b0, b);
        check("R5 new n after reload", b, 2);

        // R8: external clock
        @(negedge clk);
        rst = 1'b1;
        div_n = 8'd0; ext_clk_sel = 1'b1; sclk_in = 1'b0;
        do_reset();
        a = 0;
        repeat (40) begin
            @(negedge clk);
            a = a + int'(tx_tick) + int'(rx_tick);
        end
        check("R8 internal divider ignored", a, 0);
        check("R8 sclk_oe low", int'(sclk_oe), 0);
        sclk_in = 1'b1;
        @(negedge clk);
        check("R8 no rx after 1 cycle", int'(rx_tick), 0);
        @(negedge clk);
        check("R8 rx on rising pin", int'(rx_tick), 1);
        @(negedge clk);
        check("R10 rx single cycle", int'(rx_tick), 0);
        sclk_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 tx on falling pin", int'(tx_tick), 1);

        // R9: inverted pin input
        clk_inv = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 rising pin gives tx (inv)", int'(tx_tick), 1);
        check("R9 rising pin gives no rx (inv)", int'(rx_tick), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule